// File: doc/BRIEF.md
# Broadcast Text Command Receiver

This block is one listening endpoint on a one-way, byte-wide command bus shared by several receivers. A single master sends a command line as a series of ASCII characters, one per four-phase request/acknowledge transfer. The receiver takes a character when the request is high, answers with its acknowledge, and drops the acknowledge once the request falls. The master can only move on once every receiver has answered. A zero byte ends the line.

On the zero byte the receiver holds back its acknowledge and walks the stored line one character per cycle. It splits the line into space-separated tokens: a device type, an instance name, a command, and optional argument fields. It compares the first two tokens with its own configured names and latches the position and length of the command token and of the first argument tokens. Only then does it acknowledge the terminator. In this way the receiver itself sets how long the master waits at the end of each line.

A one-cycle command pulse marks a line addressed to this receiver that carries a command. The stored characters stay readable through a read port, so downstream logic can fetch the token text by index.

Top module: `textcmd_rx`

## Requirements
- R1: After a synchronous reset the acknowledge, command pulse, both match flags and the overflow flag are all 0.
- R2: A non-zero character seen with the request high is acknowledged on the next clock edge (acknowledge reaches 1). The acknowledge returns to 0 on the edge after the request is seen low.
- R3: The non-zero characters of a line are stored in arrival order from index 0. After the line ends, they stay readable at `lineRdIdx` on `lineRdChar` (combinational read) until the next line writes them.
- R4: The terminator (byte 0x00) is not acknowledged until the whole stored line has been scanned. With N stored characters, the acknowledge rises N+2 clock edges after the edge that captured the terminator.
- R5: Tokens are separated by one or more space characters (0x20). Leading and trailing spaces produce no token.
- R6: `devMatch` is 1 only when the first token equals DEV_ID in both length and every character. `instMatch` is 1 only when the second token equals INST_ID in the same way. Both are updated with the terminator's acknowledge.
- R7: `cmdValid` pulses for exactly one cycle, in the cycle the terminator's acknowledge rises. It pulses only when both names match and the line holds at least three tokens.
- R8: `cmdStart`/`cmdLen` give the buffer index and length of the third token. Argument slot k (k from 0) gives the (k+4)th token in field k of `argStart`/`argLen`, and is 0 when that token is absent. `argCount` is the number of tokens past the third, saturated at MAX_ARGS.
- R9: Characters beyond DEPTH in a line are dropped and tokens are formed from the first DEPTH characters only. `lineOverflow` reports 1 with that line's results and 0 with the next line that fits.
- R10: Every character is acknowledged whatever the line's address, including lines whose names do not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdReq | input | 1 | Request from the bus master |
| cmdData | input | 8 | ASCII character, 0x00 ends the line |
| cmdAck | output | 1 | This receiver's acknowledge |
| lineRdIdx | input | $clog2(DEPTH) | Read index into the line buffer |
| lineRdChar | output | 8 | Character stored at lineRdIdx |
| cmdValid | output | 1 | One-cycle pulse: addressed line with a command |
| devMatch | output | 1 | First token equals DEV_ID |
| instMatch | output | 1 | Second token equals INST_ID |
| lineOverflow | output | 1 | Last line was longer than DEPTH |
| cmdStart | output | $clog2(DEPTH+1) | Buffer index of the command token |
| cmdLen | output | $clog2(DEPTH+1) | Length of the command token |
| argStart | output | MAX_ARGS*$clog2(DEPTH+1) | Argument token start indices, slot k in field k |
| argLen | output | MAX_ARGS*$clog2(DEPTH+1) | Argument token lengths, slot k in field k |
| argCount | output | $clog2(MAX_ARGS+1) | Number of argument tokens, saturated |

## Verification
The bench builds the receiver with a 16-character buffer, two argument slots, device name "gen" and instance name "vin1". The short buffer lets a 22-character line truncate a token in the middle and raise the overflow flag. The two slots let a line with four trailing fields show the argument count saturating. Name checks cover a wrong device, an instance that is too short, and an instance with an extra character, so length and content mismatches are each exercised. The terminator latency is measured for lines from empty to full length.

// File: rtl/textcmd_pkg.sv
package textcmd_pkg;

  typedef struct packed {
    logic wrChar;
    logic scanStep;
    logic finish;
    logic clearLine;
  } lineStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_SCAN,
    ST_FIN,
    ST_NACK
  } rxState_t;

endpackage

// File: rtl/textcmd_ctrl.sv
module textcmd_ctrl
  import textcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmdReq,
  input  logic        charIsNull,
  input  logic        scanDone,
  output logic        cmdAck,
  output lineStrobe_t strb
);

  rxState_t state, nextState;
  logic     ackNext;

  always_comb begin
    strb      = '0;
    nextState = state;
    ackNext   = cmdAck;
    case (state)
      ST_IDLE: if (cmdReq) begin
        if (charIsNull) nextState = ST_SCAN;
        else begin
          strb.wrChar = 1'b1;
          ackNext     = 1'b1;
          nextState   = ST_HOLD;
        end
      end
      ST_HOLD: if (!cmdReq) begin
        ackNext   = 1'b0;
        nextState = ST_IDLE;
      end
      ST_SCAN: begin
        if (scanDone) nextState = ST_FIN;
        else          strb.scanStep = 1'b1;
      end
      ST_FIN: begin
        strb.finish = 1'b1;
        ackNext     = 1'b1;
        nextState   = ST_NACK;
      end
      ST_NACK: if (!cmdReq) begin
        ackNext        = 1'b0;
        strb.clearLine = 1'b1;
        nextState      = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cmdAck <= 1'b0;
    end else begin
      state  <= nextState;
      cmdAck <= ackNext;
    end
  end

  // R2
  ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cmdAck) |-> $past(cmdReq));

  // R2
  ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cmdAck) |-> !$past(cmdReq));

endmodule

// File: rtl/textcmd_dpath.sv
module textcmd_dpath
  import textcmd_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int MAX_ARGS = 4,
  parameter int ID_MAX   = 8,
  parameter logic [8*ID_MAX-1:0] DEV_ID  = "gen",
  parameter int DEV_LEN  = 3,
  parameter logic [8*ID_MAX-1:0] INST_ID = "ch0",
  parameter int INST_LEN = 3,
  parameter int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int IDX_W    = $clog2(DEPTH + 1),
  parameter int CNT_W    = $clog2(MAX_ARGS + 1)
)(
  input  logic                      clk,
  input  logic                      rst,
  input  lineStrobe_t               strb,
  input  logic [7:0]                cmdData,
  input  logic [AW-1:0]             lineRdIdx,
  output logic [7:0]                lineRdChar,
  output logic                      scanDone,
  output logic                      cmdValid,
  output logic                      devMatch,
  output logic                      instMatch,
  output logic                      lineOverflow,
  output logic [IDX_W-1:0]          cmdStart,
  output logic [IDX_W-1:0]          cmdLen,
  output logic [MAX_ARGS*IDX_W-1:0] argStart,
  output logic [MAX_ARGS*IDX_W-1:0] argLen,
  output logic [CNT_W-1:0]          argCount
);

  localparam int NTOK = 3 + MAX_ARGS;
  localparam int TA   = $clog2(NTOK);
  localparam int TK_W = $clog2(NTOK + 2);
  localparam logic [TK_W-1:0] NTOK_V = TK_W'(NTOK);
  localparam logic [TK_W-1:0] FULL_V = TK_W'(NTOK);
  localparam logic [TK_W-1:0] THREE_V = TK_W'(3);
  localparam logic [IDX_W-1:0] DEPTH_V = IDX_W'(DEPTH);

  logic [7:0]       lineBuf [DEPTH];
  logic [IDX_W-1:0] wrCnt, scanIdx;
  logic             ovfSticky, inTok;
  logic [TK_W-1:0]  tokCnt;
  logic [IDX_W-1:0] tokStart [NTOK];
  logic [IDX_W-1:0] tokLen   [NTOK];
  logic [IDX_W-1:0] argStartR [MAX_ARGS];
  logic [IDX_W-1:0] argLenR   [MAX_ARGS];

  logic [7:0]  curChar;
  logic        isSpace, lastValid, devHit, instHit;
  logic [TA-1:0] tokSlot, lastSlot;

  assign scanDone   = (scanIdx == wrCnt);
  assign curChar    = lineBuf[scanIdx[AW-1:0]];
  assign isSpace    = (curChar == 8'h20);
  assign tokSlot    = tokCnt[TA-1:0];
  assign lastSlot   = TA'(tokCnt - TK_W'(1));
  assign lastValid  = (tokCnt != '0) && (tokCnt <= NTOK_V);
  assign lineRdChar = lineBuf[lineRdIdx];

  function automatic logic tokEq(input logic [IDX_W-1:0] st,
                                 input logic [IDX_W-1:0] ln,
                                 input logic [8*ID_MAX-1:0] id,
                                 input int idLen);
    logic eq;
    eq = (ln == IDX_W'(idLen));
    for (int b = 0; b < ID_MAX; b++) begin
      if (b < idLen) begin
        if (lineBuf[AW'(st + IDX_W'(idLen - 1 - b))] != id[8*b +: 8]) eq = 1'b0;
      end
    end
    return eq;
  endfunction

  always_comb begin
    devHit  = (tokCnt >= TK_W'(1)) && tokEq(tokStart[0], tokLen[0], DEV_ID, DEV_LEN);
    instHit = (tokCnt >= TK_W'(2)) && tokEq(tokStart[1], tokLen[1], INST_ID, INST_LEN);
  end

  always_ff @(posedge clk) begin
    if (strb.wrChar && (wrCnt < DEPTH_V)) lineBuf[wrCnt[AW-1:0]] <= cmdData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrCnt        <= '0;
      scanIdx      <= '0;
      ovfSticky    <= 1'b0;
      inTok        <= 1'b0;
      tokCnt       <= '0;
      cmdValid     <= 1'b0;
      devMatch     <= 1'b0;
      instMatch    <= 1'b0;
      lineOverflow <= 1'b0;
      cmdStart     <= '0;
      cmdLen       <= '0;
      argCount     <= '0;
      for (int t = 0; t < NTOK; t++) begin
        tokStart[t] <= '0;
        tokLen[t]   <= '0;
      end
      for (int a = 0; a < MAX_ARGS; a++) begin
        argStartR[a] <= '0;
        argLenR[a]   <= '0;
      end
    end else begin
      cmdValid <= 1'b0;
      if (strb.wrChar) begin
        if (wrCnt < DEPTH_V) wrCnt <= wrCnt + 1'b1;
        else                 ovfSticky <= 1'b1;
      end
      if (strb.scanStep) begin
        scanIdx <= scanIdx + 1'b1;
        if (isSpace) inTok <= 1'b0;
        else if (!inTok) begin
          inTok <= 1'b1;
          if (tokCnt < NTOK_V) begin
            tokStart[tokSlot] <= scanIdx;
            tokLen[tokSlot]   <= IDX_W'(1);
          end
          if (tokCnt <= NTOK_V) tokCnt <= tokCnt + 1'b1;
        end else if (lastValid) begin
          tokLen[lastSlot] <= tokLen[lastSlot] + 1'b1;
        end
      end
      if (strb.finish) begin
        devMatch     <= devHit;
        instMatch    <= instHit;
        cmdValid     <= devHit && instHit && (tokCnt >= THREE_V);
        lineOverflow <= ovfSticky;
        cmdStart     <= tokStart[2];
        cmdLen       <= tokLen[2];
        for (int a = 0; a < MAX_ARGS; a++) begin
          argStartR[a] <= tokStart[3+a];
          argLenR[a]   <= tokLen[3+a];
        end
        if (tokCnt >= FULL_V)       argCount <= CNT_W'(MAX_ARGS);
        else if (tokCnt >= THREE_V) argCount <= CNT_W'(tokCnt - THREE_V);
        else                        argCount <= '0;
      end
      if (strb.clearLine) begin
        wrCnt     <= '0;
        scanIdx   <= '0;
        ovfSticky <= 1'b0;
        inTok     <= 1'b0;
        tokCnt    <= '0;
        for (int t = 0; t < NTOK; t++) begin
          tokStart[t] <= '0;
          tokLen[t]   <= '0;
        end
      end
    end
  end

  for (genvar g = 0; g < MAX_ARGS; g++) begin : g_argPack
    assign argStart[g*IDX_W +: IDX_W] = argStartR[g];
    assign argLen[g*IDX_W +: IDX_W]   = argLenR[g];
  end

  // R9
  buf_bound_chk: assert property (@(posedge clk) disable iff (rst)
    wrCnt <= DEPTH_V);

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    cmdValid |=> !cmdValid);

  // R7
  pulse_addr_chk: assert property (@(posedge clk) disable iff (rst)
    cmdValid |-> (devMatch && instMatch));

  // R8
  arg_sat_chk: assert property (@(posedge clk) disable iff (rst)
    argCount <= CNT_W'(MAX_ARGS));

endmodule

// File: rtl/textcmd_rx.sv
module textcmd_rx
  import textcmd_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int MAX_ARGS = 4,
  parameter int ID_MAX   = 8,
  parameter logic [8*ID_MAX-1:0] DEV_ID  = "gen",
  parameter int DEV_LEN  = 3,
  parameter logic [8*ID_MAX-1:0] INST_ID = "ch0",
  parameter int INST_LEN = 3,
  parameter int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int IDX_W    = $clog2(DEPTH + 1),
  parameter int CNT_W    = $clog2(MAX_ARGS + 1)
)(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmdReq,
  input  logic [7:0]                cmdData,
  output logic                      cmdAck,
  input  logic [AW-1:0]             lineRdIdx,
  output logic [7:0]                lineRdChar,
  output logic                      cmdValid,
  output logic                      devMatch,
  output logic                      instMatch,
  output logic                      lineOverflow,
  output logic [IDX_W-1:0]          cmdStart,
  output logic [IDX_W-1:0]          cmdLen,
  output logic [MAX_ARGS*IDX_W-1:0] argStart,
  output logic [MAX_ARGS*IDX_W-1:0] argLen,
  output logic [CNT_W-1:0]          argCount
);

  lineStrobe_t strb;
  logic        scanDone;

  textcmd_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cmdReq     (cmdReq),
    .charIsNull (cmdData == 8'h00),
    .scanDone   (scanDone),
    .cmdAck     (cmdAck),
    .strb       (strb)
  );

  textcmd_dpath #(
    .DEPTH(DEPTH), .MAX_ARGS(MAX_ARGS), .ID_MAX(ID_MAX),
    .DEV_ID(DEV_ID), .DEV_LEN(DEV_LEN),
    .INST_ID(INST_ID), .INST_LEN(INST_LEN),
    .AW(AW), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) i_dpath (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .cmdData      (cmdData),
    .lineRdIdx    (lineRdIdx),
    .lineRdChar   (lineRdChar),
    .scanDone     (scanDone),
    .cmdValid     (cmdValid),
    .devMatch     (devMatch),
    .instMatch    (instMatch),
    .lineOverflow (lineOverflow),
    .cmdStart     (cmdStart),
    .cmdLen       (cmdLen),
    .argStart     (argStart),
    .argLen       (argLen),
    .argCount     (argCount)
  );

endmodule

// File: tb/test_textcmd_rx.sv
`timescale 1ns/1ps
module test_textcmd_rx;

  localparam int DEPTH = 16;
  localparam int MAXA  = 2;
  localparam int NT    = 3 + MAXA;
  localparam int AW    = $clog2(DEPTH);
  localparam int IDX_W = $clog2(DEPTH + 1);
  localparam int CNT_W = $clog2(MAXA + 1);

  typedef struct packed {
    logic valid, dev, inst, ovf;
    logic [7:0] cnt, cmdS, cmdL;
    logic [MAXA-1:0][7:0] aS;
    logic [MAXA-1:0][7:0] aL;
  } exp_t;

  logic clk = 0, rst = 1, cmdReq = 0;
  logic [7:0] cmdData = 0;
  logic [AW-1:0] lineRdIdx = 0;
  logic cmdAck, cmdValid, devMatch, instMatch, lineOverflow;
  logic [7:0] lineRdChar;
  logic [IDX_W-1:0] cmdStart, cmdLen;
  logic [MAXA*IDX_W-1:0] argStart, argLen;
  logic [CNT_W-1:0] argCount;

  int vecs = 0, miss = 0;
  bit done = 0, nullPending = 0, pulseCheck = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  textcmd_rx #(
    .DEPTH(DEPTH), .MAX_ARGS(MAXA), .ID_MAX(8),
    .DEV_ID("gen"), .DEV_LEN(3), .INST_ID("vin1"), .INST_LEN(4)
  ) i_textcmd_rx (
    .clk(clk), .rst(rst), .cmdReq(cmdReq), .cmdData(cmdData), .cmdAck(cmdAck),
    .lineRdIdx(lineRdIdx), .lineRdChar(lineRdChar), .cmdValid(cmdValid),
    .devMatch(devMatch), .instMatch(instMatch), .lineOverflow(lineOverflow),
    .cmdStart(cmdStart), .cmdLen(cmdLen), .argStart(argStart), .argLen(argLen),
    .argCount(argCount)
  );

  task automatic chk(input string tag, input int act, input int expv);
    vecs++;
    if (act != expv) begin
      miss++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic exp_t model(input string s);
    exp_t e;
    int st[NT];
    int ln[NT];
    int n, tc, cnt;
    bit inT;
    string t0, t1;
    e = '0;
    for (int i = 0; i < NT; i++) begin st[i] = 0; ln[i] = 0; end
    n = (s.len() > DEPTH) ? DEPTH : s.len();
    tc = 0; inT = 0;
    for (int i = 0; i < n; i++) begin
      if (s[i] == " ") inT = 0;
      else if (!inT) begin
        inT = 1;
        if (tc < NT) begin st[tc] = i; ln[tc] = 1; end
        tc++;
      end else if (tc - 1 < NT) ln[tc-1]++;
    end
    t0 = (tc >= 1) ? s.substr(st[0], st[0] + ln[0] - 1) : "";
    t1 = (tc >= 2) ? s.substr(st[1], st[1] + ln[1] - 1) : "";
    e.dev   = (tc >= 1) && (t0 == "gen");
    e.inst  = (tc >= 2) && (t1 == "vin1");
    e.valid = e.dev && e.inst && (tc >= 3);
    e.ovf   = (s.len() > DEPTH);
    cnt = (tc < 3) ? 0 : ((tc - 3 > MAXA) ? MAXA : tc - 3);
    e.cnt  = 8'(cnt);
    e.cmdS = 8'(st[2]);
    e.cmdL = 8'(ln[2]);
    for (int a = 0; a < MAXA; a++) begin
      e.aS[a] = 8'(st[3+a]);
      e.aL[a] = 8'(ln[3+a]);
    end
    return e;
  endfunction

  // Driver: pushes the expected result, then sends the line and its terminator.
  task automatic sendLine(input string s);
    bit ackOk;
    int n, stored;
    ackOk = 1;
    q.push_back(model(s));
    for (int i = 0; i < s.len(); i++) begin
      cmdData = s[i];
      cmdReq  = 1;
      n = 0;
      do begin @(negedge clk); n++; end while (!cmdAck && n < 8);
      if (n != 1) ackOk = 0;
      cmdReq = 0;
      n = 0;
      do begin @(negedge clk); n++; end while (cmdAck && n < 8);
      if (cmdAck) ackOk = 0;
    end
    chk("R10 every character acknowledged", ackOk, 1);
    stored = (s.len() > DEPTH) ? DEPTH : s.len();
    cmdData = 8'h00;
    cmdReq = 1;
    nullPending = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (!cmdAck && n < DEPTH + 20);
    chk("R4 terminator ack latency", n, stored + 3);
    cmdReq = 0;
    n = 0;
    do begin @(negedge clk); n++; end while (cmdAck && n < 8);
    chk("R2 ack released after request drop", cmdAck, 0);
  endtask

  // Monitor: compares results when the terminator acknowledge appears.
  always @(negedge clk) begin
    if (pulseCheck) begin
      chk("R7 pulse lasts one cycle", cmdValid, 0);
      pulseCheck = 0;
    end
    if (nullPending && cmdAck) begin
      exp_t e;
      nullPending = 0;
      if (q.size() == 0) chk("R7 unexpected result", 1, 0);
      else begin
        e = q.pop_front();
        chk("R7 cmdValid", cmdValid, e.valid);
        chk("R6 devMatch", devMatch, e.dev);
        chk("R6 instMatch", instMatch, e.inst);
        chk("R9 overflow flag", lineOverflow, e.ovf);
        chk("R8/R5 cmdStart", cmdStart, e.cmdS);
        chk("R8 cmdLen", cmdLen, e.cmdL);
        chk("R8 argCount", argCount, e.cnt);
        for (int a = 0; a < MAXA; a++) begin
          chk("R8 argStart", argStart[a*IDX_W +: IDX_W], e.aS[a]);
          chk("R8 argLen", argLen[a*IDX_W +: IDX_W], e.aL[a]);
        end
        if (cmdValid) pulseCheck = 1;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ack after reset", cmdAck, 0);
    chk("R1 cmdValid after reset", cmdValid, 0);
    chk("R1 devMatch after reset", devMatch, 0);
    chk("R1 instMatch after reset", instMatch, 0);
    chk("R1 overflow after reset", lineOverflow, 0);

    sendLine("gen vin1 sine");
    // R3 stored characters readable by index
    lineRdIdx = 4;
    @(negedge clk);
    chk("R3 read index 4", lineRdChar, "v");
    lineRdIdx = 12;
    @(negedge clk);
    chk("R3 read index 12", lineRdChar, "e");

    sendLine("gen vin1 dc 5 7");
    sendLine(" gen  vin1   go ");       // R5 space runs
    sendLine("gen vin1 a b c d");       // R8 saturation
    sendLine("gan vin1 go");            // R6 device mismatch, R10
    sendLine("gen vin go");             // R6 short instance
    sendLine("gen vin12 go");           // R6 long instance
    sendLine("gen vin1");               // R7 no command token
    sendLine("gen vin1 xx 1234567890"); // R9 overflow
    sendLine("gen vin1 go");            // R9 flag cleared
    sendLine("");                       // R4 empty line
    sendLine("gen   vin1 w 42");
    repeat (4) @(negedge clk);
    chk("R7 all results observed", q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vecs++;
      miss++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

endmodule